// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Clock-Speed Mode

This block carries a stream of data words from one clock domain to another that is fully unrelated to it. Words enter on the write clock through a valid/ready pair and leave on the read clock through a second valid/ready pair. The storage is a small array of flops with a multiplexer on the read side. Each side keeps a binary position counter and shares its position with the other side only as a Gray-coded value. On the receiving side that value passes through a two-flop synchronizer.

The capacity is 2^AW - 1 words. One position code always stays unused, so a full FIFO and an empty FIFO never share the same pointer pattern. Each domain has its own active-low asynchronous reset.

A build parameter states which side is expected to have the faster clock. With a fast writer, a word is stored on one write clock and its position is published on the next write clock. On the read side, the word is usable in the same cycle that valid rises. With a fast reader, a word and its position are published on the same write clock. The read side then waits one full read cycle after it sees a new entry before it raises valid. Both settings stay correct when the clocks relate the other way round; they only lose throughput.

Back-pressure rules: a write is accepted on a write-clock edge where wr_valid and wr_ready are both high. wr_ready low means the FIFO is full, and the writer may change or drop its word freely. Once rd_valid is high, it stays high with rd_data unchanged until a read-clock edge where rd_ready is also high.

Top module: `xclk_fifo`

## Requirements
- R1: After reset, wr_ready is 1 and rd_valid is 0.
- R2: Every accepted word is delivered exactly once, in the order it was accepted, with no extra words.
- R3: With no reads, wr_ready falls after exactly 2^AW - 1 accepted words (3 words for AW=2, 7 for AW=3).
- R4: A write attempted while wr_ready is 0 is ignored: the write position does not move and the word never appears at the read side.
- R5: rd_ready asserted while rd_valid is 0 is ignored: the read position does not move and no later word is skipped.
- R6: While rd_valid is 1 and rd_ready is 0, on the next read clock rd_valid is still 1 and rd_data is unchanged.
- R7: The published Gray write position changes in at most one bit per write clock.
- R8: With MODE = FAST_WRITER (1), rd_data is the correct word in the same cycle rd_valid rises, and a reader that stays ready takes words on consecutive read clocks.
- R9: With MODE = FAST_READER (0), rd_valid is 0 on the read clock that follows an accepted read, so an entry must be seen for a full read cycle before it is offered.
- R10: Both modes deliver correct data whether the write clock is faster or slower than the read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_valid | input | 1 | Writer offers wr_data |
| wr_ready | output | 1 | FIFO can accept a word (low = full) |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_valid | output | 1 | rd_data holds the oldest stored word |
| rd_ready | input | 1 | Reader takes rd_data |
| rd_data | output | DW | Oldest stored word |

## Verification
The bench builds four copies. Two use MODE=FAST_WRITER with AW=2 and two use MODE=FAST_READER with AW=3. Within each mode, one copy has the faster write clock and the other has the faster read clock. The small AW=2 capacity makes the full boundary and pointer wrap occur often during random traffic. AW=3 exercises a wider Gray pointer and a 7-word fill. Running each mode against both clock relations reaches the case where the selected mode does not match the actual clocks, as well as the case where it does.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // Which domain is expected to run the faster clock.
  typedef enum bit {
    FAST_READER = 1'b0,
    FAST_WRITER = 1'b1
  } speed_mode_e;
endpackage

// File: rtl/xclk_gray_sync.sv
module xclk_gray_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xclk_fifo_wside.sv
module xclk_fifo_wside
  import xclk_fifo_pkg::*;
#(
  parameter speed_mode_e MODE = FAST_WRITER,
  parameter int          AW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] rsync,
  output logic          push,
  output logic [AW-1:0] wbin,
  output logic [AW-1:0] wgray_pub
);
  logic [AW-1:0] wnxt, gray_nxt, gray_cur;

  always_comb begin
    wnxt     = wbin + AW'(1);
    gray_nxt = wnxt ^ (wnxt >> 1);
    gray_cur = wbin ^ (wbin >> 1);
  end

  // Full: one step ahead would land on the reader's position.
  assign wr_ready = (gray_nxt != rsync);
  assign push     = wr_valid & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wbin <= '0;
    else if (push) wbin <= wnxt;
  end

  generate
    if (MODE == FAST_WRITER) begin : g_late_pub
      // Position follows the stored word by one write clock.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wgray_pub <= '0;
        else        wgray_pub <= gray_cur;
      end
    end else begin : g_same_pub
      // Position is published on the same edge as the word.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    wgray_pub <= '0;
        else if (push) wgray_pub <= gray_nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/xclk_fifo_rside.sv
module xclk_fifo_rside
  import xclk_fifo_pkg::*;
#(
  parameter speed_mode_e MODE = FAST_WRITER,
  parameter int          AW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic [AW-1:0] wsync,
  output logic          rd_valid,
  output logic          pop,
  output logic [AW-1:0] rbin,
  output logic [AW-1:0] rgray
);
  logic [AW-1:0] rnxt;
  logic          avail;

  assign avail = (rgray != wsync);
  assign pop   = rd_valid & rd_ready;
  assign rnxt  = rbin + AW'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rnxt;
      rgray <= rnxt ^ (rnxt >> 1);
    end
  end

  generate
    if (MODE == FAST_WRITER) begin : g_direct
      assign rd_valid = avail;
    end else begin : g_settle
      // Entry must be seen for one whole read cycle before it is offered.
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= avail & ~pop;
      end
      assign rd_valid = avail & seen_q;
    end
  endgenerate
endmodule

// File: rtl/xclk_fifo_store.sv
module xclk_fifo_store #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int SLOTS = 1 << AW;

  logic [DW-1:0] mem [SLOTS];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter speed_mode_e MODE = FAST_WRITER,
  parameter int          AW   = 2,
  parameter int          DW   = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  logic          push, pop;
  logic [AW-1:0] w_bin, w_gray, r_bin, r_gray, w_gray_rd, r_gray_wr;

  xclk_fifo_wside #(.MODE(MODE), .AW(AW)) u_wside (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rsync(r_gray_wr), .push(push), .wbin(w_bin), .wgray_pub(w_gray)
  );

  xclk_fifo_rside #(.MODE(MODE), .AW(AW)) u_rside (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_ready(rd_ready), .wsync(w_gray_rd),
    .rd_valid(rd_valid), .pop(pop), .rbin(r_bin), .rgray(r_gray)
  );

  xclk_gray_sync #(.W(AW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(w_gray), .q(w_gray_rd)
  );

  xclk_gray_sync #(.W(AW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(r_gray), .q(r_gray_wr)
  );

  xclk_fifo_store #(.AW(AW), .DW(DW)) u_store (
    .wr_clk(wr_clk), .we(push), .waddr(w_bin), .wdata(wr_data),
    .raddr(r_bin), .rdata(rd_data)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk
  import xclk_fifo_pkg::*;
#(
  parameter speed_mode_e MODE = FAST_WRITER,
  parameter int          AW   = 2,
  parameter int          DW   = 8
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] w_bin,
  input logic [AW-1:0] w_gray,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic [AW-1:0] r_bin
);
  // R4
  wr_full_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_valid && !wr_ready) |=> $stable(w_bin));

  // R7
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  // R5
  rd_empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_ready && !rd_valid) |=> $stable(r_bin));

  // R6
  rd_offer_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9
  rd_settle_gap_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (MODE == FAST_READER && rd_valid && rd_ready) |=> !rd_valid);
endmodule

bind xclk_fifo xclk_fifo_chk #(.MODE(MODE), .AW(AW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .w_bin(w_bin), .w_gray(w_gray), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .r_bin(r_bin)
);

// File: tb/test_xclk_fifo.sv
module fifo_harness
  import xclk_fifo_pkg::*;
#(
  parameter speed_mode_e MODE = FAST_WRITER,
  parameter int          AW   = 2,
  parameter int          WP   = 10,
  parameter int          RP   = 26,
  parameter int          SEED = 1
) ();
  localparam int DW    = 8;
  localparam int DEPTH = (1 << AW) - 1;

  logic          wclk = 0, rclk = 0;
  logic          wrst_n = 0, rrst_n = 0;
  logic          wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_valid;
  logic [DW-1:0] rd_data;

  always #(WP/2) wclk = ~wclk;
  always #(RP/2) rclk = ~rclk;

  xclk_fifo #(.MODE(MODE), .AW(AW), .DW(DW)) i_xclk_fifo (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int checks = 0, bad = 0, pops = 0, b2b = 0, rd_pct = 0;
  bit done = 0, prev_pop = 0;
  logic [DW-1:0] model_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s mode=%0d aw=%0d act=%0d exp=%0d", tag, MODE, AW, act, exp);
    end
  endtask

  function automatic bit want(input int pct);
    return ($urandom_range(99) < pct);
  endfunction

  // Reader: decides rd_ready away from the edge; a pop happens at the next edge.
  always @(negedge rclk) begin
    if (rrst_n) begin
      if (MODE == FAST_READER && prev_pop)
        chk(!rd_valid, "R9 valid after pop", rd_valid, 0);
      rd_ready = want(rd_pct);
      if (rd_valid && rd_ready) begin
        if (model_q.size() == 0) chk(0, "R2 extra word", rd_data, -1);
        else begin
          logic [DW-1:0] e;
          e = model_q.pop_front();
          chk(rd_data == e, "R2 R8 R10 order", rd_data, e);
        end
        if (prev_pop) b2b++;
        pops++;
        prev_pop = 1;
      end else prev_pop = 0;
    end
  end

  task automatic wait_drain();
    for (int i = 0; i < 4000 && model_q.size() != 0; i++) @(negedge wclk);
    chk(model_q.size() == 0, "R2 drained", model_q.size(), 0);
  endtask

  initial begin
    int sent, b2b0, pops0;
    void'($urandom(SEED));
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    wrst_n = 1;
    rrst_n = 1;
    @(negedge wclk);
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
    @(negedge rclk);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);

    // Random traffic, R2/R10
    rd_pct = 60;
    sent = 0;
    while (sent < 300) begin
      @(negedge wclk);
      wr_valid = want(70);
      wr_data  = DW'($urandom);
      if (wr_valid && wr_ready) begin
        model_q.push_back(wr_data);
        sent++;
      end
    end
    @(negedge wclk);
    wr_valid = 0;
    rd_pct = 100;
    wait_drain();

    // Fill with reader stopped: R3, then writes while full: R4
    rd_pct = 0;
    repeat (10) @(negedge rclk);
    repeat (10) @(negedge wclk);
    sent = 0;
    for (int i = 0; i < 3 * DEPTH + 4; i++) begin
      @(negedge wclk);
      wr_valid = 1;
      wr_data  = DW'(8'h40 + i);
      if (wr_ready) begin
        model_q.push_back(wr_data);
        sent++;
      end
    end
    @(negedge wclk);
    wr_valid = 0;
    chk(sent == DEPTH, "R3 capacity", sent, DEPTH);
    chk(wr_ready == 0, "R3 full", wr_ready, 0);
    b2b0 = b2b;
    rd_pct = 100;
    wait_drain();
    if (MODE == FAST_WRITER)
      chk(b2b > b2b0, "R8 back-to-back", b2b - b2b0, 1);
    repeat (20) @(negedge rclk);
    chk(rd_valid == 0, "R4 ignored write", rd_valid, 0);

    // Reads while empty: R5
    pops0 = pops;
    repeat (20) @(negedge rclk);
    chk(pops == pops0, "R5 empty pops", pops - pops0, 0);
    @(negedge wclk);
    wr_valid = 1;
    wr_data  = 8'hA5;
    while (!wr_ready) @(negedge wclk);
    model_q.push_back(wr_data);
    @(negedge wclk);
    wr_valid = 0;
    wait_drain();
    repeat (10) @(negedge rclk);
    chk(pops == pops0 + 1, "R5 single word", pops - pops0, 1);
    chk(rd_valid == 0, "R5 empty after", rd_valid, 0);
    done = 1;
  end
endmodule

module test_xclk_fifo;
  import xclk_fifo_pkg::*;
  localparam int CLK_PERIOD = 10;

  // R10: each mode against both clock relations
  fifo_harness #(.MODE(FAST_WRITER), .AW(2), .WP(CLK_PERIOD), .RP(CLK_PERIOD*2+6), .SEED(11)) h_wf_wfast ();
  fifo_harness #(.MODE(FAST_WRITER), .AW(2), .WP(CLK_PERIOD*2+4), .RP(CLK_PERIOD), .SEED(22)) h_wf_rfast ();
  fifo_harness #(.MODE(FAST_READER), .AW(3), .WP(CLK_PERIOD*3), .RP(CLK_PERIOD+4), .SEED(33)) h_rf_rfast ();
  fifo_harness #(.MODE(FAST_READER), .AW(3), .WP(CLK_PERIOD), .RP(CLK_PERIOD*2+2), .SEED(44)) h_rf_wfast ();

  initial begin
    int total, badn;
    bit timeout;
    timeout = 0;
    fork
      wait (h_wf_wfast.done && h_wf_rfast.done && h_rf_rfast.done && h_rf_wfast.done);
      begin
        #(CLK_PERIOD * 150000);
        timeout = 1;
      end
    join_any
    total = h_wf_wfast.checks + h_wf_rfast.checks + h_rf_rfast.checks + h_rf_wfast.checks;
    badn  = h_wf_wfast.bad + h_wf_rfast.bad + h_rf_rfast.bad + h_rf_wfast.bad;
    if (timeout) begin
      total++;
      badn++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, badn);
    $finish;
  end
endmodule